// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block decides which serial-port interrupt a host should service first and drives the single interrupt request line. Three sources compete. The first is received data waiting, taken from a data-ready input. The second is a hidden transmit-pending flag. The third is a modem-status-changed flag. Each source is gated by its own bit of an interrupt-enable mask. The block presents the winning source as an 8-bit identification code. The host then reads that code to learn the cause.

The two hidden flags are kept inside the block. Host register accesses clear them or re-arm them as side effects. A data write models a transmit hand-off: the holding register is reported busy for `HANDOFF_LAT` cycles, and then transmit-pending is raised again. The ID and IRQ outputs are combinational from the registered flags and the live inputs. As a result, an ID read returns the value from before its own side effects, and the updated value appears on the following cycle.

Top module: `uart_irq_ident`

## Requirements
- R1: The ID output follows a fixed priority. Received data with mask bit 0 set gives 0x04. Otherwise transmit-pending with mask bit 1 set gives 0x02. Otherwise status-changed with mask bit 2 set gives 0x06. Otherwise the ID is 0x01. Mask bit 3 has no effect.
- R2: `irq` is 1 exactly when the ID is not 0x01.
- R3: A data write clears holding-empty and transmit-pending from the next cycle. Exactly `HANDOFF_LAT` cycles after the write, holding-empty and transmit-pending are both set again.
- R4: An ID read clears transmit-pending only if the ID returned in that cycle is 0x02. A read that returns any other code leaves transmit-pending unchanged.
- R5: Every ID read clears the status-changed flag. A status-change pulse sets the flag. If the pulse and an ID read fall in the same cycle, the flag stays set.
- R6: An enable write while holding-empty is 1 sets transmit-pending. An enable write during a hand-off has no effect.
- R7: During an ID read cycle, the ID shows the pre-read state. The effect of the read is visible on the next cycle.
- R8: After reset, holding-empty is 1, both flags are clear, the ID is 0x01 and `irq` is 0.
- R9: A data write during a hand-off restarts the `HANDOFF_LAT` count from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_ready | input | 1 | A received byte is waiting |
| en_mask | input | 4 | Interrupt-enable mask (bit 0 receive, bit 1 transmit, bit 2 status) |
| wr_data | input | 1 | One-cycle pulse: host wrote the transmit data register |
| wr_enable | input | 1 | One-cycle pulse: host wrote the enable register |
| rd_iid | input | 1 | One-cycle pulse: host reads the ID register this cycle |
| status_evt | input | 1 | One-cycle pulse: modem status lines changed |
| iid | output | 8 | Interrupt identification code |
| irq | output | 1 | Interrupt request level |
| holding_empty | output | 1 | Transmit holding register is empty |

## Verification
The bench builds the block with `HANDOFF_LAT` = 3. This keeps every hand-off short enough to walk cycle by cycle and still separates the first and last busy cycles from the restart case. With the flags this small, the bench can sweep every combination of data-ready, the full 4-bit mask and both hidden flags against an arithmetic priority model. Directed sequences then cover the clearing and re-arming side effects and the collisions within a single cycle.

// File: rtl/uart_iid_pkg.sv
// Shared constants for the interrupt identification block.
// Source index order is priority order: index 0 wins.
package uart_iid_pkg;
    localparam int ID_W   = 8;
    localparam int MASK_W = 4;
    localparam int NSRC   = 3;

    localparam logic [ID_W-1:0] ID_NONE = 8'h01;
    localparam logic [ID_W-1:0] ID_RX   = 8'h04;
    localparam logic [ID_W-1:0] ID_TX   = 8'h02;
    localparam logic [ID_W-1:0] ID_STS  = 8'h06;

    typedef enum logic [1:0] {
        SRC_RX  = 2'd0,
        SRC_TX  = 2'd1,
        SRC_STS = 2'd2
    } src_e;

    // Code reported for a source index.
    function automatic logic [ID_W-1:0] src_code(input int idx);
        case (idx)
            0:       return ID_RX;
            1:       return ID_TX;
            2:       return ID_STS;
            default: return ID_NONE;
        endcase
    endfunction
endpackage

// File: rtl/uart_tx_handoff.sv
// Transmit hand-off timer.
// A data write marks the holding register busy for HANDOFF_LAT cycles.
// Assumes HANDOFF_LAT >= 1. A write while busy restarts the count.
module uart_tx_handoff #(
    parameter int HANDOFF_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_data,
    output logic holding_empty,
    output logic done
);
    localparam int CNT_W = $clog2(HANDOFF_LAT + 1);

    logic             busy;
    logic [CNT_W-1:0] cnt;

    // The count ends on the last busy cycle unless a new write restarts it.
    assign done          = busy && (cnt == CNT_W'(1)) && !wr_data;
    assign holding_empty = !busy;

    // Load on write, count down while busy, release at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (wr_data) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(HANDOFF_LAT);
        end else if (busy) begin
            cnt  <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_iid_flags.sv
// Hidden interrupt flags: transmit-pending and status-changed.
// Assumes every access input is a one-cycle pulse. cur_iid is the ID shown
// in the current cycle; a read uses it to decide whether to clear tx_pend.
module uart_iid_flags
    import uart_iid_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_data,
    input  logic            wr_enable,
    input  logic            rd_iid,
    input  logic            status_evt,
    input  logic            holding_empty,
    input  logic            handoff_done,
    input  logic [ID_W-1:0] cur_iid,
    output logic            tx_pend,
    output logic            sts_pend
);
    // Transmit-pending: write clears, end of hand-off or enable write arms,
    // and a read that reports it clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_pend <= 1'b0;
        else if (wr_data)
            tx_pend <= 1'b0;
        else if (handoff_done)
            tx_pend <= 1'b1;
        else if (wr_enable && holding_empty)
            tx_pend <= 1'b1;
        else if (rd_iid && (cur_iid[2:0] == ID_TX[2:0]))
            tx_pend <= 1'b0;
    end

    // Status-changed: a new event wins over a read in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sts_pend <= 1'b0;
        else if (status_evt)
            sts_pend <= 1'b1;
        else if (rd_iid)
            sts_pend <= 1'b0;
    end
endmodule

// File: rtl/uart_iid_encode.sv
// Priority encoder from gated requests to the ID code and the IRQ level.
// Assumes request index 0 has the highest priority.
module uart_iid_encode
    import uart_iid_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] en,
    output logic [ID_W-1:0] iid,
    output logic            irq
);
    logic [NSRC-1:0] live;

    assign live = req & en;

    // Walk from lowest to highest priority so the highest live source wins.
    always_comb begin
        iid = ID_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (live[i]) iid = src_code(i);
        end
    end

    // Request line: any gated source is live.
    assign irq = |live;
endmodule

// File: rtl/uart_irq_ident.sv
// Top of the interrupt identification block.
// Joins the hand-off timer, the hidden flags and the priority encoder.
// Assumes the access inputs are one-cycle pulses, synchronous to clk.
module uart_irq_ident
    import uart_iid_pkg::*;
#(
    parameter int HANDOFF_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_ready,
    input  logic [MASK_W-1:0] en_mask,
    input  logic              wr_data,
    input  logic              wr_enable,
    input  logic              rd_iid,
    input  logic              status_evt,
    output logic [ID_W-1:0]   iid,
    output logic              irq,
    output logic              holding_empty
);
    logic            handoff_done;
    logic            tx_pend;
    logic            sts_pend;
    logic [NSRC-1:0] req;
    logic            unused_mask_hi;

    assign unused_mask_hi = ^en_mask[MASK_W-1:NSRC];

    uart_tx_handoff #(.HANDOFF_LAT(HANDOFF_LAT)) u_handoff (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_data       (wr_data),
        .holding_empty (holding_empty),
        .done          (handoff_done)
    );

    uart_iid_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_data       (wr_data),
        .wr_enable     (wr_enable),
        .rd_iid        (rd_iid),
        .status_evt    (status_evt),
        .holding_empty (holding_empty),
        .handoff_done  (handoff_done),
        .cur_iid       (iid),
        .tx_pend       (tx_pend),
        .sts_pend      (sts_pend)
    );

    // Requests in priority order.
    always_comb begin
        req          = '0;
        req[SRC_RX]  = data_ready;
        req[SRC_TX]  = tx_pend;
        req[SRC_STS] = sts_pend;
    end

    uart_iid_encode u_enc (
        .req (req),
        .en  (en_mask[NSRC-1:0]),
        .iid (iid),
        .irq (irq)
    );
endmodule

// File: rtl/uart_irq_ident_chk.sv
// Checker for uart_irq_ident, attached with bind below.
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       data_ready,
    input logic [3:0] en_mask,
    input logic       wr_data,
    input logic       wr_enable,
    input logic       rd_iid,
    input logic       status_evt,
    input logic [7:0] iid,
    input logic       irq,
    input logic       holding_empty,
    input logic       tx_pend
);
    // R1: received data with its enable bit always wins.
    assert_rx_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && en_mask[0]) |-> (iid == 8'h04));

    // R2: the request line agrees with the code.
    assert_irq_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iid != 8'h01));

    // R3: a data write makes the holding register busy.
    assert_write_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> !holding_empty);

    // R5: a read with no new event removes the status code.
    assert_read_clears_sts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_iid && !status_evt) |=> (iid != 8'h06));

    // R6: an enable write while empty arms transmit-pending.
    assert_enable_arms_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_enable && holding_empty && !wr_data) |=> tx_pend);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .data_ready    (data_ready),
    .en_mask       (en_mask),
    .wr_data       (wr_data),
    .wr_enable     (wr_enable),
    .rd_iid        (rd_iid),
    .status_evt    (status_evt),
    .iid           (iid),
    .irq           (irq),
    .holding_empty (holding_empty),
    .tx_pend       (tx_pend)
);

// File: tb/test_uart_irq_ident.sv
`timescale 1ns/1ps
module test_uart_irq_ident;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_ready = 1'b0;
    logic [3:0] en_mask = 4'h0;
    logic       wr_data = 1'b0;
    logic       wr_enable = 1'b0;
    logic       rd_iid = 1'b0;
    logic       status_evt = 1'b0;
    logic [7:0] iid;
    logic       irq;
    logic       holding_empty;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    uart_irq_ident #(.HANDOFF_LAT(LAT)) i_uart_irq_ident (
        .clk           (clk),
        .rst_n         (rst_n),
        .data_ready    (data_ready),
        .en_mask       (en_mask),
        .wr_data       (wr_data),
        .wr_enable     (wr_enable),
        .rd_iid        (rd_iid),
        .status_evt    (status_evt),
        .iid           (iid),
        .irq           (irq),
        .holding_empty (holding_empty)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    function automatic int model_id(input bit dr, input bit [3:0] m, input bit tp, input bit sp);
        if (dr && m[0]) return 8'h04;
        if (tp && m[1]) return 8'h02;
        if (sp && m[2]) return 8'h06;
        return 8'h01;
    endfunction

    // Advance to the next negedge, then let combinational outputs settle.
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; data_ready = 1'b0; en_mask = 4'h0;
        wr_data = 1'b0; wr_enable = 1'b0; rd_iid = 1'b0; status_evt = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    // Pulse helpers: raise at a negedge, drop at the next one.
    task automatic pulse_wr_data();
        @(negedge clk); wr_data = 1'b1;
        @(negedge clk); wr_data = 1'b0; #1;
    endtask
    task automatic pulse_wr_enable();
        @(negedge clk); wr_enable = 1'b1;
        @(negedge clk); wr_enable = 1'b0; #1;
    endtask
    task automatic pulse_status();
        @(negedge clk); status_evt = 1'b1;
        @(negedge clk); status_evt = 1'b0; #1;
    endtask
    // Read: returns the ID seen in the read cycle itself (R7).
    task automatic do_read(output int seen);
        @(negedge clk); rd_iid = 1'b1; #1;
        seen = iid;
        @(negedge clk); rd_iid = 1'b0; #1;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seen;

        // R8: reset state
        do_reset();
        chk("R8 iid", iid, 8'h01);
        chk("R8 irq", irq, 0);
        chk("R8 holding_empty", holding_empty, 1);
        en_mask = 4'hF; #1;
        chk("R8 no pending with full mask", iid, 8'h01);

        // R1 and R2: sweep of data-ready, mask and both hidden flags
        for (int sp = 0; sp < 2; sp++) begin
            for (int tp = 0; tp < 2; tp++) begin
                do_reset();
                if (tp != 0) pulse_wr_enable();
                if (sp != 0) pulse_status();
                for (int dr = 0; dr < 2; dr++) begin
                    for (int m = 0; m < 16; m++) begin
                        data_ready = dr[0];
                        en_mask = m[3:0];
                        #1;
                        chk("R1 sweep iid", iid, model_id(dr[0], m[3:0], tp[0], sp[0]));
                        chk("R2 sweep irq", irq, model_id(dr[0], m[3:0], tp[0], sp[0]) != 8'h01);
                    end
                end
                data_ready = 1'b0;
            end
        end

        // R3: hand-off timing
        do_reset();
        en_mask = 4'h2;
        pulse_wr_enable();
        chk("R6 armed after enable write", iid, 8'h02);
        @(negedge clk); wr_data = 1'b1;
        step(); wr_data = 1'b0;
        chk("R3 busy after write", holding_empty, 0);
        chk("R3 pending cleared by write", iid, 8'h01);
        for (int k = 2; k <= LAT; k++) begin
            step();
            chk("R3 still busy", holding_empty, 0);
        end
        step();
        chk("R3 empty after latency", holding_empty, 1);
        chk("R3 pending after latency", iid, 8'h02);

        // R6: enable write during hand-off does nothing
        do_reset();
        en_mask = 4'h2;
        @(negedge clk); wr_data = 1'b1;
        @(negedge clk); wr_data = 1'b0; wr_enable = 1'b1;
        @(negedge clk); wr_enable = 1'b0; #1;
        chk("R6 enable while busy ignored", iid, 8'h01);

        // R9: second write restarts the count
        do_reset();
        @(negedge clk); wr_data = 1'b1;
        @(negedge clk); wr_data = 1'b0;
        @(negedge clk); wr_data = 1'b1;
        step(); wr_data = 1'b0;
        for (int k = 2; k <= LAT; k++) begin
            step();
            chk("R9 busy after restart", holding_empty, 0);
        end
        step();
        chk("R9 empty after restarted count", holding_empty, 1);

        // R4 and R7: read reporting 0x02 clears tx pending
        do_reset();
        en_mask = 4'h2;
        pulse_wr_enable();
        do_read(seen);
        chk("R7 read sees pre-read code", seen, 8'h02);
        chk("R4 tx pending cleared by read", iid, 8'h01);

        // R4: read returning 0x04 keeps tx pending
        do_reset();
        en_mask = 4'h3;
        pulse_wr_enable();
        data_ready = 1'b1; #1;
        do_read(seen);
        chk("R4 read returned rx code", seen, 8'h04);
        data_ready = 1'b0; #1;
        chk("R4 tx pending kept", iid, 8'h02);

        // R5: read clears status flag
        do_reset();
        en_mask = 4'h4;
        pulse_status();
        chk("R5 status code", iid, 8'h06);
        do_read(seen);
        chk("R7 read sees status code", seen, 8'h06);
        chk("R5 status cleared", iid, 8'h01);

        // R5: read returning another code still clears it
        do_reset();
        en_mask = 4'h5;
        pulse_status();
        data_ready = 1'b1; #1;
        do_read(seen);
        chk("R5 read returned rx code", seen, 8'h04);
        data_ready = 1'b0; #1;
        chk("R5 status cleared by other read", iid, 8'h01);

        // R5: event and read in the same cycle keeps the flag
        do_reset();
        en_mask = 4'h4;
        @(negedge clk); rd_iid = 1'b1; status_evt = 1'b1;
        @(negedge clk); rd_iid = 1'b0; status_evt = 1'b0; #1;
        chk("R5 event wins over read", iid, 8'h06);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule